// File: doc/BRIEF.md
# DRAM bank prerequisite resolver

This block holds the functional state of every bank in one DRAM channel: whether the bank is open, and if it is, which row it holds. A scheduler asks it a question through the query port. The question is: "to carry out this command at this address, which command must go on the bus first?" The answer comes back in the same cycle. It gives the prerequisite command, whether the addressed bank is open, and whether it is open on the requested row. A `ready` flag combines that answer with a timing verdict that the block is given, because timing is enforced elsewhere. A query never changes state.

A second, independent port reports commands that are actually placed on the bus. The block checks each issued command against the same rules as a query. A legal command changes the bank state at the next clock edge. An illegal one is flagged on `iss_err` in the same cycle and leaves every bank untouched. Commands address one bank, every bank of a rank, or one bank index in every bank group of a rank.

The issue port is a plain strobe with no back-pressure. The block accepts every command the cycle it is presented, so the port has no ready signal, and a caller never has to hold or retry.

Top module: `dram_bank_resolver`

## Requirements

Command codes used on `q_cmd`, `iss_cmd` and `q_prereq`: 0 open, 1 close-one, 2 close-rank, 3 close-same-index, 4 read, 5 write, 6 read-then-close, 7 write-then-close, 8 refresh-rank, 9 refresh-same-index, 15 none.

- R1: After reset every bank is closed. A read (4) query to any bank returns prerequisite 0, with `q_row_open` and `q_row_hit` both low.
- R2: An access query (codes 4 to 7) to a closed bank returns prerequisite 0 (open).
- R3: An access query to a bank open on the requested row returns the queried code itself as prerequisite, with `q_row_hit` high. For any command, `q_row_open` and `q_row_hit` describe the bank selected by rank, group and bank.
- R4: An access query to a bank open on a different row returns prerequisite 1 (close-one), with `q_row_open` high and `q_row_hit` low.
- R5: `q_ready` is high exactly when the command is defined, the prerequisite equals the queried command, and `q_timing_ok` is high. A query has no effect on state.
- R6: An open (0) query to a closed bank returns 0, and to an open bank returns 1. A legal issued open marks the bank open with `iss_row` from the next clock edge.
- R7: Close-one (1) is its own prerequisite in any bank state and closes the addressed bank. Read-then-close (6) and write-then-close (7) close the bank after their access.
- R8: Close-rank (2) is its own prerequisite and closes every bank of the addressed rank. The other rank is left as it was.
- R9: Refresh-rank (8) returns prerequisite 2 while any bank of the addressed rank is open, and returns 8 once all of them are closed.
- R10: Close-same-index (3) is its own prerequisite and closes the addressed bank index in every bank group of the rank. Refresh-same-index (9) returns 3 while any of those banks is open, and returns 9 otherwise.
- R11: An issued command whose prerequisite differs from it, or that has `iss_timing_ok` low, raises `iss_err` in that cycle and changes no bank.
- R12: An undefined code (10 to 15) returns prerequisite 15, is never ready, and raises `iss_err` when issued.

## Ports

| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| q_cmd | input | 4 | Queried command code |
| q_rank | input | 1 | Queried rank |
| q_bg | input | 2 | Queried bank group |
| q_bank | input | 2 | Queried bank within group |
| q_row | input | 16 | Queried row |
| q_timing_ok | input | 1 | External timing verdict for the query |
| q_prereq | output | 4 | Command needed next |
| q_ready | output | 1 | Query command may issue now |
| q_row_hit | output | 1 | Addressed bank open on q_row |
| q_row_open | output | 1 | Addressed bank open |
| iss_valid | input | 1 | A command is issued this cycle |
| iss_cmd | input | 4 | Issued command code |
| iss_rank | input | 1 | Issued rank |
| iss_bg | input | 2 | Issued bank group |
| iss_bank | input | 2 | Issued bank |
| iss_row | input | 16 | Issued row |
| iss_timing_ok | input | 1 | External timing verdict for the issue |
| iss_err | output | 1 | Issued command is illegal and was dropped |

## Verification

Several properties are checked on every cycle.
- The query outputs stay consistent with each other: a hit implies an open bank, closed-bank accesses ask for an open, conflicts ask for a close, and ready never appears without timing.
- A legal open records its row.
- A flagged issue leaves all bank state stable.
- A legal rank refresh only happens with the whole rank closed.
- Undefined codes are always rejected.

Only the bench's scenarios can show the remaining behaviour. That covers which banks a rank-wide or same-index close really clears, that the other rank survives, and that auto-close commands close their bank. It also covers the exact prerequisite code for every command at every bank, which the bench sweeps after each step.

// File: rtl/dram_bank_resolver_pkg.sv
package dram_bank_resolver_pkg;
  localparam int CMD_W = 4;

  typedef enum logic [CMD_W-1:0] {
    CMD_OPEN       = 4'd0,
    CMD_CLOSE_ONE  = 4'd1,
    CMD_CLOSE_RANK = 4'd2,
    CMD_CLOSE_SAME = 4'd3,
    CMD_READ       = 4'd4,
    CMD_WRITE      = 4'd5,
    CMD_READ_AC    = 4'd6,
    CMD_WRITE_AC   = 4'd7,
    CMD_REF_RANK   = 4'd8,
    CMD_REF_SAME   = 4'd9,
    CMD_NONE       = 4'd15
  } dram_cmd_e;
endpackage

// File: rtl/bank_state_array.sv
module bank_state_array
  import dram_bank_resolver_pkg::*;
#(
  parameter int NRANK = 2,
  parameter int NBG   = 4,
  parameter int NBK   = 4,
  parameter int ROW_W = 16,
  localparam int NB   = NRANK * NBG * NBK,
  localparam int RK_W = (NRANK > 1) ? $clog2(NRANK) : 1,
  localparam int BG_W = (NBG > 1) ? $clog2(NBG) : 1,
  localparam int BK_W = (NBK > 1) ? $clog2(NBK) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       upd_en,
  input  logic [CMD_W-1:0]           upd_cmd,
  input  logic [RK_W-1:0]            upd_rank,
  input  logic [BG_W-1:0]            upd_bg,
  input  logic [BK_W-1:0]            upd_bank,
  input  logic [ROW_W-1:0]           upd_row,
  output logic [NB-1:0]              open_o,
  output logic [NB-1:0][ROW_W-1:0]   rows_o
);
  for (genvar r = 0; r < NRANK; r++) begin : g_rank
    for (genvar g = 0; g < NBG; g++) begin : g_grp
      for (genvar k = 0; k < NBK; k++) begin : g_bank
        localparam int IDX = (r * NBG + g) * NBK + k;
        logic             b_open;
        logic [ROW_W-1:0] b_row;
        logic             in_rank, same_idx, single;

        assign in_rank  = (upd_rank == RK_W'(r));
        assign same_idx = in_rank && (upd_bank == BK_W'(k));
        assign single   = same_idx && (upd_bg == BG_W'(g));

        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            b_open <= 1'b0;
            b_row  <= '0;
          end else if (upd_en) begin
            case (dram_cmd_e'(upd_cmd))
              CMD_OPEN: if (single) begin
                b_open <= 1'b1;
                b_row  <= upd_row;
              end
              CMD_CLOSE_ONE, CMD_READ_AC, CMD_WRITE_AC: if (single) begin
                b_open <= 1'b0;
                b_row  <= '0;
              end
              CMD_CLOSE_RANK: if (in_rank) begin
                b_open <= 1'b0;
                b_row  <= '0;
              end
              CMD_CLOSE_SAME: if (same_idx) begin
                b_open <= 1'b0;
                b_row  <= '0;
              end
              default: ;
            endcase
          end
        end

        assign open_o[IDX] = b_open;
        assign rows_o[IDX] = b_row;
      end
    end
  end
endmodule

// File: rtl/prereq_logic.sv
module prereq_logic
  import dram_bank_resolver_pkg::*;
#(
  parameter int NRANK = 2,
  parameter int NBG   = 4,
  parameter int NBK   = 4,
  parameter int ROW_W = 16,
  localparam int NB   = NRANK * NBG * NBK,
  localparam int IDX_W = (NB > 1) ? $clog2(NB) : 1,
  localparam int RK_W = (NRANK > 1) ? $clog2(NRANK) : 1,
  localparam int BG_W = (NBG > 1) ? $clog2(NBG) : 1,
  localparam int BK_W = (NBK > 1) ? $clog2(NBK) : 1
) (
  input  logic [CMD_W-1:0]           cmd_i,
  input  logic [RK_W-1:0]            rank_i,
  input  logic [BG_W-1:0]            bg_i,
  input  logic [BK_W-1:0]            bank_i,
  input  logic [ROW_W-1:0]           row_i,
  input  logic [NB-1:0]              open_i,
  input  logic [NB-1:0][ROW_W-1:0]   rows_i,
  output logic [CMD_W-1:0]           prereq_o,
  output logic                       known_o,
  output logic                       row_hit_o,
  output logic                       row_open_o
);
  int               idx;
  logic [IDX_W-1:0] sel;
  logic             b_open, b_hit, rank_busy, same_busy;

  always_comb begin
    idx       = (int'(rank_i) * NBG + int'(bg_i)) * NBK + int'(bank_i);
    sel       = (idx < NB) ? IDX_W'(idx) : '0;
    b_open    = (idx < NB) && open_i[sel];
    b_hit     = b_open && (rows_i[sel] == row_i);
    rank_busy = 1'b0;
    same_busy = 1'b0;
    for (int b = 0; b < NB; b++) begin
      if (open_i[b] && (b / (NBG * NBK) == int'(rank_i))) begin
        rank_busy = 1'b1;
        if (b % NBK == int'(bank_i)) same_busy = 1'b1;
      end
    end
  end

  always_comb begin
    known_o  = 1'b1;
    prereq_o = CMD_NONE;
    case (dram_cmd_e'(cmd_i))
      CMD_OPEN:       prereq_o = b_open ? CMD_CLOSE_ONE : CMD_OPEN;
      CMD_CLOSE_ONE,
      CMD_CLOSE_RANK,
      CMD_CLOSE_SAME: prereq_o = cmd_i;
      CMD_READ, CMD_WRITE, CMD_READ_AC, CMD_WRITE_AC:
        prereq_o = !b_open ? CMD_OPEN : (b_hit ? cmd_i : CMD_CLOSE_ONE);
      CMD_REF_RANK:   prereq_o = rank_busy ? CMD_CLOSE_RANK : CMD_REF_RANK;
      CMD_REF_SAME:   prereq_o = same_busy ? CMD_CLOSE_SAME : CMD_REF_SAME;
      default:        known_o  = 1'b0;
    endcase
  end

  assign row_hit_o  = b_hit;
  assign row_open_o = b_open;
endmodule

// File: rtl/dram_bank_resolver.sv
module dram_bank_resolver
  import dram_bank_resolver_pkg::*;
#(
  parameter int NRANK = 2,
  parameter int NBG   = 4,
  parameter int NBK   = 4,
  parameter int ROW_W = 16,
  localparam int NB   = NRANK * NBG * NBK,
  localparam int RK_W = (NRANK > 1) ? $clog2(NRANK) : 1,
  localparam int BG_W = (NBG > 1) ? $clog2(NBG) : 1,
  localparam int BK_W = (NBK > 1) ? $clog2(NBK) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CMD_W-1:0] q_cmd,
  input  logic [RK_W-1:0]  q_rank,
  input  logic [BG_W-1:0]  q_bg,
  input  logic [BK_W-1:0]  q_bank,
  input  logic [ROW_W-1:0] q_row,
  input  logic             q_timing_ok,
  output logic [CMD_W-1:0] q_prereq,
  output logic             q_ready,
  output logic             q_row_hit,
  output logic             q_row_open,
  input  logic             iss_valid,
  input  logic [CMD_W-1:0] iss_cmd,
  input  logic [RK_W-1:0]  iss_rank,
  input  logic [BG_W-1:0]  iss_bg,
  input  logic [BK_W-1:0]  iss_bank,
  input  logic [ROW_W-1:0] iss_row,
  input  logic             iss_timing_ok,
  output logic             iss_err
);
  logic [NB-1:0]            open_vec;
  logic [NB-1:0][ROW_W-1:0] row_vec;
  logic                     q_known, i_known, i_hit, i_open, upd_en;
  logic [CMD_W-1:0]         i_prereq;

  prereq_logic #(.NRANK(NRANK), .NBG(NBG), .NBK(NBK), .ROW_W(ROW_W)) query_i (
    .cmd_i(q_cmd), .rank_i(q_rank), .bg_i(q_bg), .bank_i(q_bank), .row_i(q_row),
    .open_i(open_vec), .rows_i(row_vec),
    .prereq_o(q_prereq), .known_o(q_known), .row_hit_o(q_row_hit), .row_open_o(q_row_open)
  );

  prereq_logic #(.NRANK(NRANK), .NBG(NBG), .NBK(NBK), .ROW_W(ROW_W)) issue_i (
    .cmd_i(iss_cmd), .rank_i(iss_rank), .bg_i(iss_bg), .bank_i(iss_bank), .row_i(iss_row),
    .open_i(open_vec), .rows_i(row_vec),
    .prereq_o(i_prereq), .known_o(i_known), .row_hit_o(i_hit), .row_open_o(i_open)
  );

  assign q_ready = q_known && (q_prereq == q_cmd) && q_timing_ok;
  assign upd_en  = iss_valid && i_known && (i_prereq == iss_cmd) && iss_timing_ok;
  assign iss_err = iss_valid && !upd_en;

  bank_state_array #(.NRANK(NRANK), .NBG(NBG), .NBK(NBK), .ROW_W(ROW_W)) state_i (
    .clk(clk), .rst_n(rst_n), .upd_en(upd_en), .upd_cmd(iss_cmd),
    .upd_rank(iss_rank), .upd_bg(iss_bg), .upd_bank(iss_bank), .upd_row(iss_row),
    .open_o(open_vec), .rows_o(row_vec)
  );

  logic unused_iss_flags;
  assign unused_iss_flags = i_hit ^ i_open;
endmodule

// File: rtl/dram_bank_resolver_chk.sv
module dram_bank_resolver_chk #(
  parameter int NRANK = 2,
  parameter int NBG   = 4,
  parameter int NBK   = 4,
  parameter int ROW_W = 16,
  localparam int NB   = NRANK * NBG * NBK,
  localparam int RK_W = (NRANK > 1) ? $clog2(NRANK) : 1,
  localparam int BG_W = (NBG > 1) ? $clog2(NBG) : 1,
  localparam int BK_W = (NBK > 1) ? $clog2(NBK) : 1
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [3:0]               q_cmd,
  input logic [3:0]               q_prereq,
  input logic                     q_ready,
  input logic                     q_timing_ok,
  input logic                     q_row_hit,
  input logic                     q_row_open,
  input logic                     iss_valid,
  input logic [3:0]               iss_cmd,
  input logic [RK_W-1:0]          iss_rank,
  input logic [BG_W-1:0]          iss_bg,
  input logic [BK_W-1:0]          iss_bank,
  input logic [ROW_W-1:0]         iss_row,
  input logic                     iss_err,
  input logic [NB-1:0]            open_vec,
  input logic [NB-1:0][ROW_W-1:0] row_vec
);
  int            iss_idx;
  logic [NB-1:0] rank_mask;
  logic          q_access;

  always_comb begin
    iss_idx = (int'(iss_rank) * NBG + int'(iss_bg)) * NBK + int'(iss_bank);
    for (int b = 0; b < NB; b++) rank_mask[b] = (b / (NBG * NBK) == int'(iss_rank));
    q_access = (q_cmd >= 4'd4) && (q_cmd <= 4'd7);
  end

  AST_CLOSED_ACCESS_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    q_access && !q_row_open |-> q_prereq == 4'd0); // R2
  AST_HIT_NEEDS_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    q_row_hit |-> q_row_open); // R3
  AST_CONFLICT_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    q_access && q_row_open && !q_row_hit |-> q_prereq == 4'd1); // R4
  AST_READY_NEEDS_TIMING: assert property (@(posedge clk) disable iff (!rst_n)
    q_ready |-> q_timing_ok); // R5
  AST_OPEN_RECORDS_ROW: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid && !iss_err && iss_cmd == 4'd0 |=>
      open_vec[$past(iss_idx)] && row_vec[$past(iss_idx)] == $past(iss_row)); // R6
  AST_REF_RANK_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid && !iss_err && iss_cmd == 4'd8 |-> (open_vec & rank_mask) == '0); // R9
  AST_ERR_HOLDS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid && iss_err |=> $stable(open_vec) && $stable(row_vec)); // R11
  AST_UNKNOWN_REJECTED: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid && iss_cmd > 4'd9 |-> iss_err); // R12
endmodule

bind dram_bank_resolver dram_bank_resolver_chk #(
  .NRANK(NRANK), .NBG(NBG), .NBK(NBK), .ROW_W(ROW_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .q_cmd(q_cmd), .q_prereq(q_prereq), .q_ready(q_ready),
  .q_timing_ok(q_timing_ok), .q_row_hit(q_row_hit), .q_row_open(q_row_open),
  .iss_valid(iss_valid), .iss_cmd(iss_cmd), .iss_rank(iss_rank), .iss_bg(iss_bg),
  .iss_bank(iss_bank), .iss_row(iss_row), .iss_err(iss_err),
  .open_vec(open_vec), .row_vec(row_vec)
);

// File: tb/dram_bank_resolver_tb_top.sv
`timescale 1ns/1ps
module dram_bank_resolver_tb_top;
  localparam int NR = 2, NG = 4, NK = 4, NB = NR * NG * NK;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [3:0]  q_cmd = '0, iss_cmd = '0;
  logic        q_rank = 1'b0, iss_rank = 1'b0;
  logic [1:0]  q_bg = '0, q_bank = '0, iss_bg = '0, iss_bank = '0;
  logic [15:0] q_row = '0, iss_row = '0;
  logic        q_timing_ok = 1'b0, iss_valid = 1'b0, iss_timing_ok = 1'b0;
  logic [3:0]  q_prereq;
  logic        q_ready, q_row_hit, q_row_open, iss_err;

  int nchk = 0, nfail = 0;
  bit          m_open [NB];
  logic [15:0] m_row  [NB];

  always #2.5 clk = ~clk;

  dram_bank_resolver dut_i (
    .clk(clk), .rst_n(rst_n), .q_cmd(q_cmd), .q_rank(q_rank), .q_bg(q_bg), .q_bank(q_bank),
    .q_row(q_row), .q_timing_ok(q_timing_ok), .q_prereq(q_prereq), .q_ready(q_ready),
    .q_row_hit(q_row_hit), .q_row_open(q_row_open), .iss_valid(iss_valid), .iss_cmd(iss_cmd),
    .iss_rank(iss_rank), .iss_bg(iss_bg), .iss_bank(iss_bank), .iss_row(iss_row),
    .iss_timing_ok(iss_timing_ok), .iss_err(iss_err)
  );

  task automatic chk(bit ok, string req, string what, int act, int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int bidx(int r, int g, int k);
    return (r * NG + g) * NK + k;
  endfunction

  function automatic bit known(int c);
    return c <= 9;
  endfunction

  function automatic int exp_pre(int c, int r, int g, int k, logic [15:0] row);
    int  b = bidx(r, g, k);
    bit  rb = 0, sb = 0;
    for (int x = 0; x < NG * NK; x++) begin
      if (m_open[r * NG * NK + x]) rb = 1;
      if (m_open[r * NG * NK + x] && (x % NK) == k) sb = 1;
    end
    case (c)
      0:       return m_open[b] ? 1 : 0;
      1, 2, 3: return c;
      4, 5, 6, 7: return !m_open[b] ? 0 : ((m_row[b] == row) ? c : 1);
      8:       return rb ? 2 : 8;
      9:       return sb ? 3 : 9;
      default: return 15;
    endcase
  endfunction

  function automatic string tag(int c, bit o, bit h);
    if (c > 9) return "R12";
    if (c == 8) return "R9";
    if (c == 9 || c == 3) return "R10";
    if (c >= 4) return !o ? "R2" : (h ? "R3" : "R4");
    if (c == 0) return "R6";
    if (c == 2) return "R8";
    return "R7";
  endfunction

  function automatic void model_apply(int c, int r, int g, int k, logic [15:0] row);
    for (int b = 0; b < NB; b++) begin
      bit rk = (b / (NG * NK)) == r;
      bit sm = rk && (b % NK) == k;
      bit one = b == bidx(r, g, k);
      if ((c == 0) && one) begin m_open[b] = 1; m_row[b] = row; end
      if (((c == 1 || c == 6 || c == 7) && one) || (c == 2 && rk) || (c == 3 && sm)) begin
        m_open[b] = 0; m_row[b] = '0;
      end
    end
  endfunction

  task automatic sweep(string ctx);
    @(negedge clk);
    for (int b = 0; b < NB; b++)
      for (int ci = 0; ci < 11; ci++)
        for (int v = 0; v < 2; v++)
          for (int t = 0; t < 2; t++) begin
            int r = b / (NG * NK), g = (b / NK) % NG, k = b % NK;
            int c = (ci < 10) ? ci : 12;
            logic [15:0] row = v ? (m_row[b] ^ 16'h0001) : m_row[b];
            int ep; bit eh, er; string tg;
            q_cmd = 4'(c); q_rank = r[0]; q_bg = 2'(g); q_bank = 2'(k);
            q_row = row; q_timing_ok = t[0];
            #1;
            ep = exp_pre(c, r, g, k, row);
            eh = m_open[b] && m_row[b] == row;
            er = known(c) && ep == c && t[0];
            tg = (ctx == "") ? tag(c, m_open[b], eh) : ctx;
            chk(q_prereq == 4'(ep), tg, $sformatf("prereq b%0d c%0d", b, c), q_prereq, ep);
            chk(q_row_open == m_open[b], (ctx == "") ? "R3" : ctx, "row_open", q_row_open, m_open[b]);
            chk(q_row_hit == eh, (ctx == "") ? "R3" : ctx, "row_hit", q_row_hit, eh);
            chk(q_ready == er, (ctx == "") ? ((c > 9) ? "R12" : "R5") : ctx, "ready", q_ready, er);
          end
  endtask

  task automatic issue(int c, int r, int g, int k, logic [15:0] row, bit tok, string req);
    bit ee;
    @(negedge clk);
    iss_valid = 1; iss_cmd = 4'(c); iss_rank = r[0]; iss_bg = 2'(g); iss_bank = 2'(k);
    iss_row = row; iss_timing_ok = tok;
    #1;
    ee = !(known(c) && exp_pre(c, r, g, k, row) == c && tok);
    chk(iss_err == ee, req, $sformatf("iss_err c%0d b%0d", c, bidx(r, g, k)), iss_err, ee);
    if (!ee) model_apply(c, r, g, k, row);
    @(posedge clk); #1;
    iss_valid = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog all-R actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    for (int b = 0; b < NB; b++) begin m_open[b] = 0; m_row[b] = '0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    sweep("R1");
    // R11: illegal issues leave state unchanged
    issue(4, 0, 1, 2, 16'h0040, 1, "R11");
    issue(0, 1, 0, 0, 16'h0041, 0, "R11");
    issue(12, 0, 0, 0, 16'h0000, 1, "R12");
    issue(15, 1, 3, 3, 16'h0000, 1, "R12");
    sweep("");
    // R6: open every bank with distinct rows
    for (int b = 0; b < NB; b++)
      issue(0, b / (NG * NK), (b / NK) % NG, b % NK, 16'(16'h0A00 + b * 37), 1, "R6");
    sweep("");
    issue(0, 0, 0, 0, 16'h1234, 1, "R11");
    issue(4, 0, 2, 1, m_row[bidx(0, 2, 1)], 0, "R11");
    issue(5, 0, 2, 1, m_row[bidx(0, 2, 1)], 1, "R3");
    // R7: auto-close and single close
    issue(6, 0, 1, 1, m_row[bidx(0, 1, 1)], 1, "R7");
    issue(7, 1, 2, 2, m_row[bidx(1, 2, 2)], 1, "R7");
    issue(1, 1, 0, 0, 16'h0000, 1, "R7");
    issue(1, 1, 0, 0, 16'h0000, 1, "R7");
    sweep("");
    // R10: same-index close then refresh
    issue(9, 0, 0, 2, 16'h0000, 1, "R10");
    issue(3, 0, 0, 2, 16'h0000, 1, "R10");
    issue(9, 0, 3, 2, 16'h0000, 1, "R10");
    sweep("");
    // R9 / R8: rank refresh blocked, rank close, refresh allowed
    issue(8, 0, 0, 0, 16'h0000, 1, "R9");
    issue(2, 0, 0, 0, 16'h0000, 1, "R8");
    issue(8, 0, 0, 0, 16'h0000, 1, "R9");
    issue(8, 1, 0, 0, 16'h0000, 1, "R9");
    sweep("");
    // R4: conflict needs a close first
    issue(0, 0, 3, 3, 16'h7777, 1, "R6");
    issue(4, 0, 3, 3, 16'h7778, 1, "R4");
    issue(1, 0, 3, 3, 16'h0000, 1, "R7");
    issue(0, 0, 3, 3, 16'h7778, 1, "R6");
    issue(4, 0, 3, 3, 16'h7778, 1, "R3");
    sweep("");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule